// File: doc/BRIEF.md
# Grouped Programmable Interrupt Priority Resolver

This block collects six interrupt requests, keeps one pending flag per request, and every cycle presents the single pending request that ranks highest under a programmable two-level priority scheme. The six requests are arranged in three pairs: pair A holds lines 3 and 5, pair B holds lines 0 and 2, and pair C holds lines 1 and 4. One field of the priority register ranks the three pairs against each other. Three single bits, one per pair, choose which member of that pair goes first.

Lines 1, 3, 4 and 5 come from on-chip event pulses. Lines 0 and 2 come from two external pins. Each pin passes through a synchronizer and then an edge detector, and the edge sensitivity of each pin is set by software. A pending flag is set by an event. It is cleared when the processor acknowledges the request currently presented, or when software writes a new value into the request register. The outputs are a registered "interrupt active" flag and a registered 3-bit index of the winning request.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, all pending flags, the priority register and the edge configuration are zero, and the outputs read inactive with index 0.
- R2: Within a pair, bit 5 selects for pair A (0: line 5 first, 1: line 3 first), bit 2 selects for pair B (0: line 0 first), and bit 1 selects for pair C (0: line 1 first).
- R3: The pair ranking code is {bit4,bit3,bit0} of the priority register: 001 gives C,B,A; 010 gives A,B,C; 011 gives A,C,B; 100 gives B,C,A; 101 gives C,A,B; 110 gives B,A,C. For example, code 001 with lines 5, 1 and 0 pending serves 1, then 0, then 5.
- R4: Ranking codes 000 and 111 ignore the pairs, and the lowest-numbered pending line wins.
- R5: irq_active_o and irq_vec_o are registered. They reflect the pending flags and the priority register as they stood before the previous rising edge. When no flag is pending, the outputs read inactive with index 0.
- R6: int_evt_i bit 0 sets line 1, bit 1 sets line 3, bit 2 sets line 4 and bit 3 sets line 5. The flag is set at the edge that samples the pulse.
- R7: A pin edge sets its pending flag at the third rising edge after the pin changes, so the outputs show it after the fourth.
- R8: Request register bits 7:6 set the pin sensitivity. 00: both pins react to falling edges. 01: line 0 reacts to rising edges and line 2 to falling edges. 10: line 2 reacts to rising edges and line 0 to falling edges. 11: both pins react to either edge.
- R9: An acknowledge while irq_active_o is high clears only the pending flag of the index on irq_vec_o.
- R10: A write to the request register loads bits 5:0 into the pending flags (bit n is line n). An acknowledge in the same cycle then clears its flag.
- R11: An event that arrives in the same cycle as a clear, whether from an acknowledge or from a write, leaves its flag set.
- R12: Bits 7:6 of a priority register write have no effect on the ranking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prio_we_i | input | 1 | Priority register write strobe |
| prio_wdata_i | input | 8 | Priority register write data |
| req_we_i | input | 1 | Request register write strobe |
| req_wdata_i | input | 8 | Pending flags (5:0) and pin sensitivity (7:6) |
| int_evt_i | input | 4 | On-chip event pulses for lines 1, 3, 4, 5 |
| ext_pin_i | input | 2 | External pins: bit 0 feeds line 0, bit 1 feeds line 2 |
| ack_i | input | 1 | Service acknowledge of the presented index |
| irq_active_o | output | 1 | A request is pending |
| irq_vec_o | output | 3 | Index of the winning request |

## Verification
Event arrival and flag clearing can both land on the same flag in the same cycle. The clear may come from an acknowledge of the presented index or from a software load of the request register. Directed cases put an event pulse in the same cycle as an acknowledge, and another in the same cycle as a load of zero. A long random phase mixes pulses, pin toggles, acknowledges and both kinds of write on every cycle. Each cycle's outputs are judged against a bench model that applies load, then clear, then set, using the group ranking computed from scores.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int unsigned NUM_IRQ = 6;
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
  localparam int unsigned NUM_GRP = NUM_IRQ / 2;
  localparam int unsigned GRP_W   = $clog2(NUM_GRP);
  localparam int unsigned NUM_PIN = 2;

  typedef logic [IDX_W-1:0] irq_idx_t;
  typedef logic [GRP_W-1:0] grp_id_t;

  typedef struct packed {
    grp_id_t first;
    grp_id_t second;
    grp_id_t third;
  } grp_order_t;

  localparam grp_id_t GRP_A = 2'd0;
  localparam grp_id_t GRP_B = 2'd1;
  localparam grp_id_t GRP_C = 2'd2;

  // member that wins when the pair's select bit is clear
  function automatic irq_idx_t grp_pref(input int g);
    case (g)
      0:       return irq_idx_t'(5);
      1:       return irq_idx_t'(0);
      default: return irq_idx_t'(1);
    endcase
  endfunction

  function automatic irq_idx_t grp_alt(input int g);
    case (g)
      0:       return irq_idx_t'(3);
      1:       return irq_idx_t'(2);
      default: return irq_idx_t'(4);
    endcase
  endfunction

  // position of the pair's select bit in the priority register
  function automatic int grp_sel_bit(input int g);
    case (g)
      0:       return 5;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic code_is_fixed(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b111);
  endfunction

  function automatic grp_order_t order_for(input logic [2:0] code);
    grp_order_t o;
    case (code)
      3'b001:  o = '{first: GRP_C, second: GRP_B, third: GRP_A};
      3'b010:  o = '{first: GRP_A, second: GRP_B, third: GRP_C};
      3'b011:  o = '{first: GRP_A, second: GRP_C, third: GRP_B};
      3'b100:  o = '{first: GRP_B, second: GRP_C, third: GRP_A};
      3'b101:  o = '{first: GRP_C, second: GRP_A, third: GRP_B};
      3'b110:  o = '{first: GRP_B, second: GRP_A, third: GRP_C};
      default: o = '{first: GRP_A, second: GRP_B, third: GRP_C};
    endcase
    return o;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
`timescale 1ns/1ps
module irq_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q;
  logic                   stable;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sync_d = pin_i;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign stable = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= stable;
    end
  end

  assign evt_o = (rise_en_i &  stable & ~last_q) |
                 (fall_en_i & ~stable &  last_q);
endmodule

// File: rtl/irq_pending_bank.sv
`timescale 1ns/1ps
module irq_pending_bank
  import irq_prio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic               load_i,
  input  logic [NUM_IRQ-1:0] load_val_i,
  input  logic               clr_i,
  input  irq_idx_t           clr_idx_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] pend_q, pend_d, base, clr_mask;
  logic               pend_en;

  always_comb begin
    base     = load_i ? load_val_i : pend_q;
    clr_mask = clr_i ? (NUM_IRQ'(1) << clr_idx_i) : '0;
    pend_d   = (base & ~clr_mask) | set_i;
    pend_en  = load_i | clr_i | (|set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
  import irq_prio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [5:0]         prio_i,
  output logic               act_o,
  output irq_idx_t           vec_o
);
  logic [NUM_GRP-1:0] grp_v;
  irq_idx_t           grp_w [NUM_GRP];
  logic [2:0]         code;
  grp_order_t         ord;
  irq_idx_t           fix_idx, vec_d;
  logic               act_d, act_q;
  irq_idx_t           vec_q;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
      localparam irq_idx_t PREF = grp_pref(g);
      localparam irq_idx_t ALT  = grp_alt(g);
      localparam int       SB   = grp_sel_bit(g);
      assign grp_v[g] = pend_i[PREF] | pend_i[ALT];
      assign grp_w[g] = prio_i[SB] ? (pend_i[ALT]  ? ALT  : PREF)
                                   : (pend_i[PREF] ? PREF : ALT);
    end
  endgenerate

  assign code = {prio_i[4], prio_i[3], prio_i[0]};
  assign ord  = order_for(code);

  always_comb begin
    fix_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend_i[i]) fix_idx = irq_idx_t'(i);
    end
  end

  always_comb begin
    act_d = |pend_i;
    if (code_is_fixed(code))        vec_d = fix_idx;
    else if (grp_v[ord.first])      vec_d = grp_w[ord.first];
    else if (grp_v[ord.second])     vec_d = grp_w[ord.second];
    else if (grp_v[ord.third])      vec_d = grp_w[ord.third];
    else                            vec_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      vec_q <= '0;
    end else begin
      act_q <= act_d;
      vec_q <= vec_d;
    end
  end

  assign act_o = act_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_resolver.sv
`timescale 1ns/1ps
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prio_we_i,
  input  logic [7:0] prio_wdata_i,
  input  logic       req_we_i,
  input  logic [7:0] req_wdata_i,
  input  logic [3:0] int_evt_i,
  input  logic [1:0] ext_pin_i,
  input  logic       ack_i,
  output logic       irq_active_o,
  output logic [2:0] irq_vec_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [5:0]         prio_q, prio_d;
  logic [1:0]         ecfg_q, ecfg_d;
  logic [NUM_PIN-1:0] rise_en, fall_en, pin_evt;
  logic [NUM_IRQ-1:0] set_vec, pend_q;
  logic               ack_ok;
  irq_idx_t           vec_w;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    prio_d = prio_we_i ? prio_wdata_i[5:0] : prio_q;
    ecfg_d = req_we_i  ? req_wdata_i[7:6]  : ecfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      prio_q <= '0;
      ecfg_q <= '0;
    end else begin
      prio_q <= prio_d;
      ecfg_q <= ecfg_d;
    end
  end

  // pin 0 -> line 0 (config bit 6), pin 1 -> line 2 (config bit 7)
  assign rise_en[0] = ecfg_q[0];
  assign fall_en[0] = ~ecfg_q[0] | ecfg_q[1];
  assign rise_en[1] = ecfg_q[1];
  assign fall_en[1] = ~ecfg_q[1] | ecfg_q[0];

  generate
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_n_int),
        .pin_i     (ext_pin_i[p]),
        .rise_en_i (rise_en[p]),
        .fall_en_i (fall_en[p]),
        .evt_o     (pin_evt[p])
      );
    end
  endgenerate

  assign set_vec = {int_evt_i[3], int_evt_i[2], int_evt_i[1],
                    pin_evt[1], int_evt_i[0], pin_evt[0]};
  assign ack_ok  = ack_i & irq_active_o;

  irq_pending_bank pend_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .set_i      (set_vec),
    .load_i     (req_we_i),
    .load_val_i (req_wdata_i[5:0]),
    .clr_i      (ack_ok),
    .clr_idx_i  (irq_vec_o),
    .pend_o     (pend_q)
  );

  irq_prio_arbiter arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pend_i (pend_q),
    .prio_i (prio_q),
    .act_o  (irq_active_o),
    .vec_o  (vec_w)
  );

  assign irq_vec_o = vec_w;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
`timescale 1ns/1ps
module irq_prio_resolver_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       req_we_i,
  input logic [5:0] req_wdata_i,
  input logic       irq_active_o,
  input logic [2:0] irq_vec_o,
  input logic [5:0] pend_i,
  input logic [5:0] set_i
);
  logic [5:0] pend_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_last <= '0;
    else         pend_last <= pend_i;
  end

  // R5
  active_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != 6'd0) |=> irq_active_o);

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == 6'd0) |=> (!irq_active_o && irq_vec_o == 3'd0));

  // R2
  vec_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_active_o |-> (irq_vec_o < 3'd6 && pend_last[irq_vec_o]));

  // R9
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_active_o && !req_we_i && !set_i[irq_vec_o])
      |=> !pend_i[$past(irq_vec_o)]);

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 6'd0) |=> ((pend_i & $past(set_i)) == $past(set_i)));

  // R10
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i && set_i == 6'd0 && !(ack_i && irq_active_o))
      |=> (pend_i == $past(req_wdata_i)));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_i        (ack_i),
  .req_we_i     (req_we_i),
  .req_wdata_i  (req_wdata_i[5:0]),
  .irq_active_o (irq_active_o),
  .irq_vec_o    (irq_vec_o),
  .pend_i       (pend_q),
  .set_i        (set_vec)
);

// File: tb/irq_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       prio_we, req_we, ack;
  logic [7:0] prio_wdata, req_wdata;
  logic [3:0] int_evt;
  logic [1:0] ext_pin;
  logic       irq_active;
  logic [2:0] irq_vec;

  int  n_chk = 0;
  int  n_err = 0;
  bit  cmp_on = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .prio_we_i    (prio_we),
    .prio_wdata_i (prio_wdata),
    .req_we_i     (req_we),
    .req_wdata_i  (req_wdata),
    .int_evt_i    (int_evt),
    .ext_pin_i    (ext_pin),
    .ack_i        (ack),
    .irq_active_o (irq_active),
    .irq_vec_o    (irq_vec)
  );

  // ---------------- reference ranking (score based) ----------------
  function automatic int grp_rank(logic [2:0] c, int g);
    int r [3];
    case (c)
      3'd1:    r = '{2, 1, 0};
      3'd2:    r = '{0, 1, 2};
      3'd3:    r = '{0, 2, 1};
      3'd4:    r = '{2, 0, 1};
      3'd5:    r = '{1, 2, 0};
      default: r = '{1, 0, 2};
    endcase
    return r[g];
  endfunction

  function automatic int ref_pick(logic [5:0] m, logic [5:0] p);
    logic [2:0] c;
    int best, bs, sc, g, pos;
    c = {p[4], p[3], p[0]};
    best = 0;
    bs = 99;
    for (int i = 0; i < 6; i++) begin
      if (m[i]) begin
        if (c == 3'd0 || c == 3'd7) sc = i;
        else begin
          case (i)
            5:       begin g = 0; pos = p[5] ? 1 : 0; end
            3:       begin g = 0; pos = p[5] ? 0 : 1; end
            0:       begin g = 1; pos = p[2] ? 1 : 0; end
            2:       begin g = 1; pos = p[2] ? 0 : 1; end
            1:       begin g = 2; pos = p[1] ? 1 : 0; end
            default: begin g = 2; pos = p[1] ? 0 : 1; end
          endcase
          sc = grp_rank(c, g) * 2 + pos;
        end
        if (sc < bs) begin bs = sc; best = i; end
      end
    end
    return best;
  endfunction

  // ---------------- cycle model ----------------
  logic [5:0] m_pend, m_prio;
  logic [1:0] m_cfg, m_s0, m_s1, m_prev;
  logic       m_act;
  logic [2:0] m_vec;

  always @(posedge clk or negedge rst_ni) begin
    logic [5:0] base, setv;
    logic [1:0] pe;
    if (!rst_ni) begin
      m_pend <= '0; m_prio <= '0; m_cfg <= '0;
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0;
      m_act <= 1'b0; m_vec <= '0;
    end else begin
      pe[0] = (m_cfg[0] & m_s1[0] & ~m_prev[0]) |
              ((~m_cfg[0] | m_cfg[1]) & ~m_s1[0] & m_prev[0]);
      pe[1] = (m_cfg[1] & m_s1[1] & ~m_prev[1]) |
              ((~m_cfg[1] | m_cfg[0]) & ~m_s1[1] & m_prev[1]);
      setv = {int_evt[3], int_evt[2], int_evt[1], pe[1], int_evt[0], pe[0]};
      base = req_we ? req_wdata[5:0] : m_pend;
      if (ack && m_act) base[m_vec] = 1'b0;
      m_pend <= base | setv;
      m_act  <= |m_pend;
      m_vec  <= (|m_pend) ? 3'(ref_pick(m_pend, m_prio)) : 3'd0;
      if (prio_we) m_prio <= prio_wdata[5:0];
      if (req_we)  m_cfg  <= req_wdata[7:6];
      m_s0   <= ext_pin;
      m_s1   <= m_s0;
      m_prev <= m_s1;
    end
  end

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // R5: every cycle, outputs against the model
  always @(negedge clk) begin
    if (cmp_on && !done)
      check({irq_active, irq_vec} == {m_act, m_vec}, "R5 cycle",
            int'({irq_active, irq_vec}), int'({m_act, m_vec}));
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prio(logic [7:0] v);
    prio_we = 1'b1; prio_wdata = v;
    @(negedge clk);
    prio_we = 1'b0;
  endtask

  task automatic wr_req(logic [7:0] v);
    req_we = 1'b1; req_wdata = v;
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic pulse_int(logic [3:0] m);
    int_evt = m;
    @(negedge clk);
    int_evt = '0;
  endtask

  task automatic expect_idle(string tag);
    check(!irq_active && irq_vec == 3'd0, tag, int'({irq_active, irq_vec}), 0);
  endtask

  task automatic ack_expect(string tag, int e);
    check(irq_active && int'(irq_vec) == e, tag, int'(irq_vec), e);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    idle(1);
  endtask

  task automatic read_order(string tag, logic [5:0] m, logic [5:0] p);
    int e;
    idle(2);
    while (m != 6'd0) begin
      e = ref_pick(m, p);
      ack_expect(tag, e);
      m[e] = 1'b0;
    end
    expect_idle(tag);
  endtask

  task automatic pin_probe(string tag, int p, logic v, bit fires);
    ext_pin[p] = v;
    idle(6);
    if (fires) ack_expect(tag, (p == 1) ? 2 : 0);
    else       expect_idle(tag);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [5:0] pm;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; prio_we = 1'b0; req_we = 1'b0; ack = 1'b0;
    prio_wdata = '0; req_wdata = '0; int_evt = '0; ext_pin = '0;
    idle(3);
    rst_ni = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    // R1: reset state
    expect_idle("R1 reset outputs");
    // R1 / R4: cleared priority register gives numeric order
    wr_req(8'h3F);
    read_order("R1 R4 fixed order after reset", 6'h3F, 6'h00);

    // R3: every ranking code, random member bits
    for (int c = 1; c <= 6; c++) begin
      pm = 6'($urandom) & 6'b100110;
      pm = pm | {1'b0, 3'(c) >> 1, 1'b0, 1'b0, 1'(c)};
      pm[4] = c[2]; pm[3] = c[1]; pm[0] = c[0];
      wr_prio({2'b00, pm});
      wr_req(8'h3F);
      read_order("R3 group code", 6'h3F, pm);
    end

    // R2: all member select combinations under code 010
    for (int mb = 0; mb < 8; mb++) begin
      pm = {mb[2], 1'b0, 1'b1, mb[1], mb[0], 1'b0};
      wr_prio({2'b00, pm});
      wr_req(8'h3F);
      read_order("R2 member select", 6'h3F, pm);
    end

    // R4: code 111 also numeric
    wr_prio(8'h19);
    wr_req(8'h3F);
    read_order("R4 code 111", 6'h3F, 6'h19);

    // R12: reserved bits of a priority write are dropped
    wr_prio(8'hC0);
    wr_req(8'h3F);
    read_order("R12 reserved bits with code 000", 6'h3F, 6'h00);
    wr_prio(8'hC1);
    wr_req(8'h3F);
    read_order("R12 reserved bits with code 001", 6'h3F, 6'h01);

    // R3 worked example: code 001, lines 5,1,0 -> 1,0,5
    wr_prio(8'h01);
    wr_req(8'h40);
    ext_pin[0] = 1'b1;
    pulse_int(4'b1001);
    idle(6);
    ack_expect("R3 example first", 1);
    ack_expect("R3 example second", 0);
    ack_expect("R3 example third", 5);
    expect_idle("R3 example drained");
    // R8: config 01, falling edge on line 0 ignored
    pin_probe("R8 cfg01 line0 fall ignored", 0, 1'b0, 1'b0);

    // R7: pin latency, config 01
    ext_pin[0] = 1'b1;
    idle(3);
    expect_idle("R7 not visible after third edge");
    idle(1);
    ack_expect("R7 visible after fourth edge", 0);
    ext_pin[0] = 1'b0;
    idle(6);

    // R8: sensitivity per configuration
    wr_prio(8'h00);
    wr_req(8'h00);
    pin_probe("R8 cfg00 line2 rise ignored", 1, 1'b1, 1'b0);
    pin_probe("R8 cfg00 line2 fall", 1, 1'b0, 1'b1);
    wr_req(8'h80);
    pin_probe("R8 cfg10 line2 rise", 1, 1'b1, 1'b1);
    pin_probe("R8 cfg10 line0 rise ignored", 0, 1'b1, 1'b0);
    pin_probe("R8 cfg10 line0 fall", 0, 1'b0, 1'b1);
    wr_req(8'hC0);
    pin_probe("R8 cfg11 line2 fall", 1, 1'b0, 1'b1);
    pin_probe("R8 cfg11 line0 rise", 0, 1'b1, 1'b1);
    pin_probe("R8 cfg11 line0 fall", 0, 1'b0, 1'b1);
    wr_req(8'h00);

    // R6: on-chip event mapping
    pulse_int(4'b0001); idle(1); ack_expect("R6 event bit0 -> line1", 1);
    pulse_int(4'b0010); idle(1); ack_expect("R6 event bit1 -> line3", 3);
    pulse_int(4'b0100); idle(1); ack_expect("R6 event bit2 -> line4", 4);
    pulse_int(4'b1000); idle(1); ack_expect("R6 event bit3 -> line5", 5);

    // R9 / R10: load a pattern, acknowledges peel it off one at a time
    wr_req(8'h28);
    read_order("R9 R10 load 3 and 5", 6'h28, 6'h00);
    wr_req(8'h3F);
    idle(1);
    wr_req(8'h00);
    idle(2);
    expect_idle("R10 load of zero clears");

    // R11: event in the same cycle as an acknowledge
    pulse_int(4'b0001);
    idle(1);
    check(irq_active && irq_vec == 3'd1, "R11 setup", int'(irq_vec), 1);
    ack = 1'b1; int_evt = 4'b0001;
    @(negedge clk);
    ack = 1'b0; int_evt = '0;
    idle(2);
    check(irq_active && irq_vec == 3'd1, "R11 set beats ack clear", int'(irq_vec), 1);
    // R11: event in the same cycle as a load of zero
    req_we = 1'b1; req_wdata = 8'h00; int_evt = 4'b0010;
    @(negedge clk);
    req_we = 1'b0; int_evt = '0;
    idle(1);
    ack_expect("R11 set beats load", 3);
    expect_idle("R11 load removed line1");

    // random phase (R5 model compare every cycle)
    for (int k = 0; k < 3000; k++) begin
      int_evt    = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      ack        = ($urandom % 3) == 0;
      prio_we    = ($urandom % 16) == 0;
      prio_wdata = 8'($urandom);
      req_we     = ($urandom % 24) == 0;
      req_wdata  = 8'($urandom);
      if (($urandom % 6) == 0) ext_pin[0] = ~ext_pin[0];
      if (($urandom % 6) == 0) ext_pin[1] = ~ext_pin[1];
      @(negedge clk);
    end
    int_evt = '0; ack = 1'b0; prio_we = 1'b0; req_we = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog all actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule